// File: doc/BRIEF.md
# Burst Block Receiver Controller

This block is the host-side controller for a fast serial file stream. It sits above a synchronous byte receiver, which hands it one byte at a time with a single-cycle ready pulse. The controller paces the sender by toggling an acknowledge line each time it wants another byte. It reads the in-band status byte that opens every block and stores the payload bytes through a simple memory write port at rising addresses.

The stream is organised in blocks. A status byte of 0 or 1 announces a full block. The end code 0x1F is followed by a byte count for the final block. Any other status aborts the transfer with an error. The first block carries a two-byte load address ahead of its payload. A mode input picks whether that address or an externally supplied one is used as the first write address. When the final counted byte has been stored, the controller raises done and reports the address that follows the last stored byte.

Top module: `burst_rx_ctrl`

## Requirements
- R1: A start pulse restarts the controller from any state. It captures the address mode and `ext_addr`, clears done and error, toggles `ack` once to request the first status byte, and waits for a status byte.
- R2: Each accepted byte toggles `ack` once, in the cycle after its `rx_valid`. The exceptions are a byte that completes the transfer and a byte that causes an error: neither toggles `ack`.
- R3: A status of 0x00 or 0x01 announces a full block of FULL_LEN (254) data bytes. In the first block the first two of these are the load address, so 252 payload bytes are written. In later blocks all 254 bytes are written.
- R4: A status of 0x1F is followed by a count byte N. Then N payload bytes are written, after the two address bytes when this is the first block, and done is raised after the N-th byte.
- R5: A count of zero ends the transfer with no further writes. In the first block this happens right after the two address bytes; in a later block it happens on the count byte itself.
- R6: Any status other than 0x00, 0x01 or 0x1F raises error. No write happens on that byte or afterwards, and `ack` does not toggle.
- R7: The load address arrives low byte first. With `use_file_addr` = 1 it becomes the first write address. With `use_file_addr` = 0 the `ext_addr` value captured at start is used. The address bytes are never written to memory.
- R8: Each stored byte is written at the current address, and the address then advances by one, wrapping modulo 2^AW.
- R9: While done is high, `end_addr` equals the address that follows the last stored byte. When no bytes were stored, it equals the start address.
- R10: Bytes arriving while idle, done or in error are ignored: no write, no `ack` change, and done and error keep their values.
- R11: Done and error are never high together. Each holds until the next start.
- R12: `mem_we` is a one-cycle pulse in the cycle after the `rx_valid` of the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new transfer (pulse) |
| use_file_addr | input | 1 | 1: load address from the file, 0: use ext_addr |
| ext_addr | input | AW | External start address |
| rx_byte | input | 8 | Byte from the synchronous receiver |
| rx_valid | input | 1 | Byte-ready pulse |
| ack | output | 1 | Acknowledge toggle requesting the next byte |
| mem_addr | output | AW | Write address |
| mem_data | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| done | output | 1 | Transfer completed |
| error | output | 1 | Transfer aborted on a bad status |
| end_addr | output | AW | Address after the last stored byte |

## Verification
The stream patterns are chosen to separate the different paths through the block:
- A multi-block file with one first full block, one later full block and a short last block. This distinguishes the 252-byte and 254-byte payload lengths and shows the status parse between blocks.
- Short single-block files in both address modes. These show whether the file address or the external address is used.
- One such file placed at the top of the address space. This exposes the address wrap.
- Zero counts in the first block and in a later block. These separate the two end paths that store nothing.
- Bad status codes in the first block and after a full block, followed by stray bytes. These show that writes stop and `ack` freezes.

Every write is compared in order against a queue of expected address and data pairs. Every byte is followed by a check of the `ack` level.

// File: rtl/burst_rx_pkg.sv
`timescale 1ns/1ps
package burst_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STATUS,
    ST_COUNT,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA,
    ST_DONE,
    ST_FAIL
  } brx_state_e;

  typedef enum logic [1:0] {
    KIND_FULL,
    KIND_LAST,
    KIND_BAD
  } brx_kind_e;

  localparam logic [7:0] END_CODE = 8'h1F;

endpackage

// File: rtl/brx_status_decode.sv
`timescale 1ns/1ps
module brx_status_decode
  import burst_rx_pkg::*;
#(
  parameter logic [7:0] LAST_CODE = END_CODE,
  parameter int unsigned FULL_MAX = 1
) (
  input  logic [7:0] code,
  output brx_kind_e  kind
);

  always_comb begin
    if (code == LAST_CODE) begin
      kind = KIND_LAST;
    end else if (code <= 8'(FULL_MAX)) begin
      kind = KIND_FULL;
    end else begin
      kind = KIND_BAD;
    end
  end

endmodule

// File: rtl/brx_len_counter.sv
`timescale 1ns/1ps
module brx_len_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          is_zero,
  output logic          is_one
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load) begin
      cnt_n = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || dec) begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CW'(1));

endmodule

// File: rtl/brx_addr_gen.sv
`timescale 1ns/1ps
module brx_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_n;

  always_comb begin
    addr_n = addr_q;
    if (load) begin
      addr_n = load_val;
    end else if (inc) begin
      addr_n = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load || inc) begin
      addr_q <= addr_n;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/burst_rx_ctrl.sv
`timescale 1ns/1ps
module burst_rx_ctrl
  import burst_rx_pkg::*;
#(
  parameter int AW       = 16,
  parameter int FULL_LEN = 254
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_file_addr,
  input  logic [AW-1:0] ext_addr,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  output logic          ack,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          mem_we,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] end_addr
);

  localparam int HDR_BYTES = 2;
  localparam int FIRST_LEN = FULL_LEN - HDR_BYTES;
  localparam int LEN_BITS  = $clog2(FULL_LEN + 1);
  localparam int CW        = (LEN_BITS > 8) ? LEN_BITS : 8;

  brx_state_e    state_q, state_n;
  logic          first_q, first_n;
  logic          last_q,  last_n;
  logic          mode_q,  mode_n;
  logic [7:0]    lo_q,    lo_n;
  logic          ack_q,   ack_n;
  logic          we_q,    we_n;
  logic [7:0]    wdata_q, wdata_n;
  logic [AW-1:0] waddr_q, waddr_n;
  logic          done_q,  done_n;
  logic          err_q,   err_n;

  brx_kind_e     kind;
  logic          cnt_load, cnt_dec, cnt_zero, cnt_one;
  logic [CW-1:0] cnt_val, cnt_cur;
  logic          a_load, a_inc;
  logic [AW-1:0] a_val, cur_addr;

  brx_status_decode #(.LAST_CODE(END_CODE), .FULL_MAX(1)) u_dec (
    .code (rx_byte),
    .kind (kind)
  );

  brx_len_counter #(.CW(CW)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .cnt      (cnt_cur),
    .is_zero  (cnt_zero),
    .is_one   (cnt_one)
  );

  brx_addr_gen #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (a_load),
    .load_val (a_val),
    .inc      (a_inc),
    .addr     (cur_addr)
  );

  // next-state logic
  always_comb begin
    state_n  = state_q;
    first_n  = first_q;
    last_n   = last_q;
    mode_n   = mode_q;
    lo_n     = lo_q;
    ack_n    = ack_q;
    we_n     = 1'b0;
    wdata_n  = wdata_q;
    waddr_n  = waddr_q;
    done_n   = done_q;
    err_n    = err_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    a_load   = 1'b0;
    a_val    = ext_addr;
    a_inc    = 1'b0;

    if (start) begin
      state_n = ST_STATUS;
      first_n = 1'b1;
      last_n  = 1'b0;
      mode_n  = use_file_addr;
      done_n  = 1'b0;
      err_n   = 1'b0;
      ack_n   = ~ack_q;
      a_load  = 1'b1;
      a_val   = ext_addr;
    end else if (rx_valid) begin
      unique case (state_q)
        ST_STATUS: begin
          unique case (kind)
            KIND_FULL: begin
              last_n   = 1'b0;
              cnt_load = 1'b1;
              ack_n    = ~ack_q;
              if (first_q) begin
                cnt_val = CW'(FIRST_LEN);
                state_n = ST_ADDR_LO;
              end else begin
                cnt_val = CW'(FULL_LEN);
                state_n = ST_DATA;
              end
            end
            KIND_LAST: begin
              state_n = ST_COUNT;
              ack_n   = ~ack_q;
            end
            default: begin
              state_n = ST_FAIL;
              err_n   = 1'b1;
            end
          endcase
        end
        ST_COUNT: begin
          last_n   = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CW'(rx_byte);
          if (first_q) begin
            state_n = ST_ADDR_LO;
            ack_n   = ~ack_q;
          end else if (rx_byte == 8'h00) begin
            state_n = ST_DONE;
            done_n  = 1'b1;
          end else begin
            state_n = ST_DATA;
            ack_n   = ~ack_q;
          end
        end
        ST_ADDR_LO: begin
          lo_n    = rx_byte;
          state_n = ST_ADDR_HI;
          ack_n   = ~ack_q;
        end
        ST_ADDR_HI: begin
          first_n = 1'b0;
          if (mode_q) begin
            a_load = 1'b1;
            a_val  = AW'({rx_byte, lo_q});
          end
          if (cnt_zero) begin
            state_n = ST_DONE;
            done_n  = 1'b1;
          end else begin
            state_n = ST_DATA;
            ack_n   = ~ack_q;
          end
        end
        ST_DATA: begin
          we_n    = 1'b1;
          wdata_n = rx_byte;
          waddr_n = cur_addr;
          a_inc   = 1'b1;
          cnt_dec = 1'b1;
          if (cnt_one) begin
            if (last_q) begin
              state_n = ST_DONE;
              done_n  = 1'b1;
            end else begin
              state_n = ST_STATUS;
              ack_n   = ~ack_q;
            end
          end else begin
            ack_n = ~ack_q;
          end
        end
        default: begin
          state_n = state_q;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      mode_q  <= 1'b0;
      lo_q    <= '0;
      ack_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      waddr_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      first_q <= first_n;
      last_q  <= last_n;
      mode_q  <= mode_n;
      lo_q    <= lo_n;
      ack_q   <= ack_n;
      we_q    <= we_n;
      wdata_q <= wdata_n;
      waddr_q <= waddr_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign ack      = ack_q;
  assign mem_we   = we_q;
  assign mem_data = wdata_q;
  assign mem_addr = waddr_q;
  assign done     = done_q;
  assign error    = err_q;
  assign end_addr = cur_addr;

endmodule

// File: rtl/burst_rx_ctrl_chk.sv
`timescale 1ns/1ps
module burst_rx_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic rx_valid,
  input logic ack,
  input logic mem_we,
  input logic done,
  input logic error
);

  // R2
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack) |-> $past(rx_valid || start));

  // R12
  we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(rx_valid) && !$past(start)));

  // R6
  no_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !mem_we);

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rx_valid));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

endmodule

bind burst_rx_ctrl burst_rx_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .rx_valid (rx_valid),
  .ack      (ack),
  .mem_we   (mem_we),
  .done     (done),
  .error    (error)
);

// File: tb/sim_burst_rx_ctrl.sv
`timescale 1ns/1ps
module sim_burst_rx_ctrl;

  localparam int AW = 16;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          use_file_addr;
  logic [AW-1:0] ext_addr;
  logic [7:0]    rx_byte;
  logic          rx_valid;
  logic          ack;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic          mem_we;
  logic          done;
  logic          error;
  logic [AW-1:0] end_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic exp_ack = 1'b0;
  logic [AW+7:0] exp_q[$];

  burst_rx_ctrl #(.AW(AW), .FULL_LEN(254)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .use_file_addr (use_file_addr),
    .ext_addr      (ext_addr),
    .rx_byte       (rx_byte),
    .rx_valid      (rx_valid),
    .ack           (ack),
    .mem_addr      (mem_addr),
    .mem_data      (mem_data),
    .mem_we        (mem_we),
    .done          (done),
    .error         (error),
    .end_addr      (end_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares every write against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected write addr", longint'(mem_addr), 0);
        end else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_data} == e, "R8", "write addr/data",
              longint'({mem_addr, mem_data}), longint'(e));
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit tog, input string req);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    if (tog) exp_ack = ~exp_ack;
    chk(ack == exp_ack, req, "ack level", longint'(ack), longint'(exp_ack));
  endtask

  task automatic data_byte(input logic [AW-1:0] a, input logic [7:0] d, input bit tog);
    exp_q.push_back({a, d});
    send(d, tog, "R8");
  endtask

  task automatic do_start(input bit mode, input logic [AW-1:0] ea);
    @(negedge clk);
    start         = 1'b1;
    use_file_addr = mode;
    ext_addr      = ea;
    @(negedge clk);
    start    = 1'b0;
    exp_ack  = ~exp_ack;
    chk(ack == exp_ack, "R1", "start ack toggle", longint'(ack), longint'(exp_ack));
    chk(!done && !error, "R1", "flags cleared", longint'({done, error}), 0);
    ext_addr = 16'h5555;
  endtask

  task automatic finish_ok(input logic [AW-1:0] ea, input string req);
    chk(done == 1'b1, req, "done", longint'(done), 1);
    chk(error == 1'b0, "R11", "error low", longint'(error), 0);
    chk(end_addr == ea, "R9", "end_addr", longint'(end_addr), longint'(ea));
    chk(exp_q.size() == 0, req, "writes pending", longint'(exp_q.size()), 0);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    rst_n         = 1'b0;
    start         = 1'b0;
    use_file_addr = 1'b0;
    ext_addr      = '0;
    rx_byte       = '0;
    rx_valid      = 1'b0;
    repeat (3) @(negedge clk);
    chk(ack == 0 && mem_we == 0 && done == 0 && error == 0, "R1", "reset state",
        longint'({ack, mem_we, done, error}), 0);
    rst_n = 1'b1;

    // R10: byte while idle is ignored
    send(8'h00, 1'b0, "R10");
    chk(!done && !error, "R10", "idle flags", longint'({done, error}), 0);

    // A: file address, first full block, later full block, short last block
    do_start(1'b1, 16'hBEEF);
    send(8'h00, 1'b1, "R3");
    send(8'h34, 1'b1, "R7");
    send(8'h12, 1'b1, "R7");
    a = 16'h1234;
    for (int i = 0; i < 252; i++) begin
      data_byte(a, 8'(i) ^ 8'h5A, 1'b1);
      a++;
    end
    chk(exp_q.size() == 0, "R3", "first block 252 writes", longint'(exp_q.size()), 0);
    send(8'h01, 1'b1, "R3");
    for (int i = 0; i < 254; i++) begin
      data_byte(a, 8'(i * 3), 1'b1);
      a++;
    end
    chk(exp_q.size() == 0, "R3", "full block 254 writes", longint'(exp_q.size()), 0);
    send(8'h1F, 1'b1, "R4");
    send(8'h05, 1'b1, "R4");
    for (int i = 0; i < 5; i++) begin
      data_byte(a, 8'hC0 + 8'(i), i != 4);
      a++;
    end
    @(negedge clk);
    finish_ok(a, "R4");

    // R10: byte after done is ignored
    send(8'h77, 1'b0, "R10");
    chk(done == 1'b1, "R11", "done held", longint'(done), 1);

    // B: external address, short first block; file address bytes ignored
    do_start(1'b0, 16'h0400);
    send(8'h1F, 1'b1, "R4");
    send(8'h03, 1'b1, "R4");
    send(8'h00, 1'b1, "R7");
    send(8'h80, 1'b1, "R7");
    data_byte(16'h0400, 8'hA1, 1'b1);
    data_byte(16'h0401, 8'hA2, 1'b1);
    data_byte(16'h0402, 8'hA3, 1'b0);
    @(negedge clk);
    finish_ok(16'h0403, "R7");

    // C: zero count in first block
    do_start(1'b1, 16'h0100);
    send(8'h1F, 1'b1, "R5");
    send(8'h00, 1'b1, "R5");
    send(8'hFE, 1'b1, "R5");
    send(8'hFF, 1'b0, "R5");
    @(negedge clk);
    finish_ok(16'hFFFE, "R5");

    // D: address wrap
    do_start(1'b1, 16'h0000);
    send(8'h1F, 1'b1, "R8");
    send(8'h04, 1'b1, "R8");
    send(8'hFE, 1'b1, "R7");
    send(8'hFF, 1'b1, "R7");
    data_byte(16'hFFFE, 8'h11, 1'b1);
    data_byte(16'hFFFF, 8'h22, 1'b1);
    data_byte(16'h0000, 8'h33, 1'b1);
    data_byte(16'h0001, 8'h44, 1'b0);
    @(negedge clk);
    finish_ok(16'h0002, "R8");

    // E: zero count in a later block
    do_start(1'b0, 16'h2000);
    send(8'h00, 1'b1, "R3");
    send(8'h99, 1'b1, "R7");
    send(8'h99, 1'b1, "R7");
    a = 16'h2000;
    for (int i = 0; i < 252; i++) begin
      data_byte(a, 8'(i + 7), 1'b1);
      a++;
    end
    send(8'h1F, 1'b1, "R5");
    send(8'h00, 1'b0, "R5");
    @(negedge clk);
    finish_ok(16'h20FC, "R5");

    // F: error after a full block, then stray bytes
    do_start(1'b0, 16'h3000);
    send(8'h01, 1'b1, "R3");
    send(8'h00, 1'b1, "R7");
    send(8'h00, 1'b1, "R7");
    a = 16'h3000;
    for (int i = 0; i < 252; i++) begin
      data_byte(a, 8'(255 - i), 1'b1);
      a++;
    end
    send(8'h02, 1'b0, "R6");
    chk(error == 1'b1, "R6", "error set", longint'(error), 1);
    chk(done == 1'b0, "R11", "done low on error", longint'(done), 0);
    send(8'h00, 1'b0, "R10");
    send(8'h1F, 1'b0, "R10");
    send(8'h05, 1'b0, "R10");
    chk(error == 1'b1, "R11", "error held", longint'(error), 1);
    chk(exp_q.size() == 0, "R6", "writes pending", longint'(exp_q.size()), 0);

    // G: bad status on the very first byte
    do_start(1'b1, 16'h4000);
    send(8'h80, 1'b0, "R6");
    chk(error == 1'b1, "R6", "error on first status", longint'(error), 1);
    send(8'h42, 1'b0, "R10");

    // restart clears error (R1)
    do_start(1'b0, 16'h5000);
    chk(error == 1'b0, "R1", "error cleared by start", longint'(error), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule